// File: doc/BRIEF.md
# DDR Mode Register and DLL Setup Sequencer

This block performs the mode-register part of bringing up a DDR SDRAM. When a request arrives it writes the extended mode register with the DLL turned on. Next it writes the base mode register with the DLL-reset bit set. It then counts clock-enabled cycles so the DLL can lock. Only after that count does it permit READ commands. The block drives the command pins, the bank address and the address bus. Between its two register writes, and whenever it is not writing, it drives NOP.

The controller supplies both 13-bit register words when it makes the request, and the block captures them at that moment. A register write goes out only after a cycle in which the controller reports that all banks are idle. The two writes are kept at least `TMRD` cycles apart. The lock count needs `LOCK_CYC` consecutive cycles with clock enable high, and it starts over whenever clock enable drops. When the sequence finishes, a one-cycle done pulse marks the end and the read-permitted flag stays high until the next request.

Top module: `ddr_mrs_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it, the pins carry NOP, bank address 0, address 0, and both done and read-permitted are low.
- R2: In every cycle that is not a register write, the pins carry NOP: chip select low and row strobe, column strobe and write enable high. A register write drives all four low.
- R3: A request taken in cycle s produces the extended-register write in cycle s+2 when the banks are idle. This write uses bank address bits BA1=0, BA0=1. Its address is the captured extended word with bit A0 forced to 0, which turns the DLL on.
- R4: A register write only ever follows a cycle in which the all-banks-idle input was high. While that input stays low, the block holds NOP and waits.
- R5: The base-register write uses BA1=0, BA0=0. Its address is the captured base word with bit A8 forced to 1, which resets the DLL. It comes no sooner than TMRD cycles after the extended write, and exactly TMRD cycles after it when the banks stay idle.
- R6: If clock enable stays high, done pulses for one cycle and read-permitted rises LOCK_CYC+1 cycles after the base write.
- R7: If clock enable is low in a lock-wait cycle c, the count restarts. Done and read-permitted then arrive in cycle c+LOCK_CYC+1, and this also holds when c is the cycle that would otherwise have ended the wait.
- R8: A request that arrives while a sequence is running has no effect on that sequence's timing or addresses.
- R9: Read-permitted goes low in the cycle after a request is accepted and stays low until done. It then stays high until the next accepted request.
- R10: Changes to the two register words after a request is accepted do not affect the addresses driven in that sequence.
- R11: Each sequence issues exactly two register writes, the extended one first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the sequence |
| banks_idle_i | input | 1 | High when all banks are idle and no burst is running |
| cke_i | input | 1 | Current clock-enable level at the memory |
| ext_mode_i | input | 13 | Extended register word, captured at request |
| base_mode_i | input | 13 | Base register word, captured at request |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address (bit 0 is BA0) |
| addr_o | output | 13 | Address bus A12..A0 |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| rd_ok_o | output | 1 | READ commands permitted |

## Verification
Two pairs of events can land in the same cycle, and the bench covers both.

The first pair is the end of the tMRD gap and the return of the idle input. With zero extra stall, the idle input is held low until exactly the cycle in which the gap is met. The base write must then appear in the very next cycle, and not one cycle later.

The second pair is a clock-enable drop and lock expiry. The bench drops clock enable in the cycle where the lock wait would otherwise end. Done must then slip by a full LOCK_CYC.

Both cases are swept with every combination of stall lengths before each write. Each sequence's event cycles are predicted arithmetically from those lengths and compared cycle by cycle.

// File: rtl/ddr_mrs_pkg.sv
`timescale 1ns/1ps
package ddr_mrs_pkg;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a request
    S_WEXT,   // waiting for idle banks before the extended write
    S_LEXT,   // extended register write on the pins
    S_GEXT,   // tMRD gap plus idle wait before the base write
    S_LBASE,  // base register write on the pins
    S_LOCK    // counting clock-enabled cycles for DLL lock
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] ctl_pins_t;
  localparam ctl_pins_t PINS_NOP = 4'b0111;
  localparam ctl_pins_t PINS_LMR = 4'b0000;

  localparam logic [BA_W-1:0] BA_EXT  = 2'b01;  // BA0=1, BA1=0
  localparam logic [BA_W-1:0] BA_BASE = 2'b00;

  function automatic logic [ADDR_W-1:0] force_bit(input logic [ADDR_W-1:0] w,
                                                  input int unsigned pos,
                                                  input logic v);
    logic [ADDR_W-1:0] r;
    r      = w;
    r[pos] = v;
    return r;
  endfunction
endpackage

// File: rtl/mrs_gap_timer.sv
`timescale 1ns/1ps
module mrs_gap_timer #(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic met_o
);
  localparam int CW = $clog2(TMRD + 1);
  logic [CW-1:0] cnt;

  // cnt is 1 in the cycle after a write; the gap is met one cycle before
  // the next write may appear on the pins.
  assign met_o = (cnt >= CW'(TMRD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= CW'(TMRD - 1);
    else if (load_i)  cnt <= CW'(1);
    else if (!met_o)  cnt <= cnt + CW'(1);
  end

  // R5
  gap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TMRD - 1) || cnt == CW'(1));
endmodule

// File: rtl/dll_lock_timer.sv
`timescale 1ns/1ps
module dll_lock_timer #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic cke_i,
  output logic expire_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  logic [CW-1:0] cnt;

  assign expire_o = run_i && cke_i && (cnt == CW'(LOCK_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                               cnt <= '0;
    else if (!run_i || !cke_i || expire_o)    cnt <= '0;
    else                                      cnt <= cnt + CW'(1);
  end

  // R7
  cke_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !cke_i) |=> !expire_o);
  // R6
  lock_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LOCK_CYC));
endmodule

// File: rtl/mrs_cmd_encode.sv
`timescale 1ns/1ps
module mrs_cmd_encode
  import ddr_mrs_pkg::*;
#(
  parameter int DLL_EN_BIT  = 0,
  parameter int DLL_RST_BIT = 8
) (
  input  seq_state_e        st_i,
  input  logic [ADDR_W-1:0] ext_word_i,
  input  logic [ADDR_W-1:0] base_word_i,
  output ctl_pins_t         pins_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    pins_o = PINS_NOP;
    ba_o   = '0;
    addr_o = '0;
    case (st_i)
      S_LEXT: begin
        pins_o = PINS_LMR;
        ba_o   = BA_EXT;
        addr_o = force_bit(ext_word_i, DLL_EN_BIT, 1'b0);
      end
      S_LBASE: begin
        pins_o = PINS_LMR;
        ba_o   = BA_BASE;
        addr_o = force_bit(base_word_i, DLL_RST_BIT, 1'b1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_mrs_seq.sv
`timescale 1ns/1ps
module ddr_mrs_seq
  import ddr_mrs_pkg::*;
#(
  parameter int TMRD        = 2,
  parameter int LOCK_CYC    = 200,
  parameter int DLL_EN_BIT  = 0,
  parameter int DLL_RST_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              banks_idle_i,
  input  logic              cke_i,
  input  logic [ADDR_W-1:0] ext_mode_i,
  input  logic [ADDR_W-1:0] base_mode_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              rd_ok_o
);
  localparam int SW = $clog2(TMRD + 1);

  seq_state_e        st, st_nx;
  logic [ADDR_W-1:0] ext_q, base_q;
  ctl_pins_t         pins;

  // named internal events
  logic accept, ext_fire, base_fire, lmr_fire, mrd_met, lock_expire;

  assign accept    = (st == S_IDLE) && start_i;
  assign ext_fire  = (st == S_LEXT);
  assign base_fire = (st == S_LBASE);
  assign lmr_fire  = ext_fire || base_fire;

  mrs_gap_timer #(.TMRD(TMRD)) u_gap (
    .clk(clk), .rst_n(rst_n), .load_i(lmr_fire), .met_o(mrd_met)
  );

  dll_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .run_i(st == S_LOCK), .cke_i(cke_i),
    .expire_o(lock_expire)
  );

  mrs_cmd_encode #(.DLL_EN_BIT(DLL_EN_BIT), .DLL_RST_BIT(DLL_RST_BIT)) u_enc (
    .st_i(st), .ext_word_i(ext_q), .base_word_i(base_q),
    .pins_o(pins), .ba_o(ba_o), .addr_o(addr_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (start_i)                 st_nx = S_WEXT;
      S_WEXT:  if (banks_idle_i)            st_nx = S_LEXT;
      S_LEXT:                               st_nx = S_GEXT;
      S_GEXT:  if (mrd_met && banks_idle_i) st_nx = S_LBASE;
      S_LBASE:                              st_nx = S_LOCK;
      S_LOCK:  if (lock_expire)             st_nx = S_IDLE;
      default:                              st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ext_q   <= '0;
      base_q  <= '0;
      done_o  <= 1'b0;
      rd_ok_o <= 1'b0;
    end else begin
      st     <= st_nx;
      done_o <= lock_expire;
      if (accept) begin
        ext_q   <= ext_mode_i;
        base_q  <= base_mode_i;
        rd_ok_o <= 1'b0;
      end else if (lock_expire) begin
        rd_ok_o <= 1'b1;
      end
    end
  end

  // checker-side state
  logic [SW-1:0] since_lmr;
  logic          ext_pending;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_lmr   <= SW'(TMRD);
      ext_pending <= 1'b0;
    end else begin
      if (lmr_fire)                    since_lmr <= SW'(1);
      else if (since_lmr < SW'(TMRD))  since_lmr <= since_lmr + SW'(1);
      if (ext_fire)       ext_pending <= 1'b1;
      else if (base_fire) ext_pending <= 1'b0;
    end
  end

  // R4
  lmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lmr_fire |-> $past(banks_idle_i));
  // R5
  mrd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lmr_fire |-> since_lmr >= SW'(TMRD));
  // R11
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_fire |-> ext_pending);
  // R2
  nop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lmr_fire |-> (pins == PINS_NOP));
  // R6
  rdok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ok_o) |-> done_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  stray_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start_i) |=> ($stable(ext_q) && $stable(base_q)));
endmodule

// File: tb/ddr_mrs_seq_tb.sv
`timescale 1ns/1ps
module ddr_mrs_seq_tb;
  localparam int TB_TMRD = 3;
  localparam int TB_LOCK = 10;

  logic clk = 1'b0;
  logic rst_n, start, idle, cke;
  logic [12:0] ext_in, base_in;
  logic cs_n, ras_n, cas_n, we_n, done, rd_ok;
  logic [1:0]  ba;
  logic [12:0] addr;

  int vec = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ddr_mrs_seq #(.TMRD(TB_TMRD), .LOCK_CYC(TB_LOCK), .DLL_EN_BIT(0), .DLL_RST_BIT(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .banks_idle_i(idle), .cke_i(cke),
    .ext_mode_i(ext_in), .base_mode_i(base_in),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .done_o(done), .rd_ok_o(rd_ok)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_nop();
    return {cs_n, ras_n, cas_n, we_n} == 4'b0111;
  endfunction
  function automatic bit is_lmr();
    return {cs_n, ras_n, cas_n, we_n} == 4'b0000;
  endfunction

  task automatic run_seq(input int d1, input int d2, input int cm);
    logic [12:0] ext_w, base_w;
    int ext_k, base_k, cd, done_k, lock_from, n_lmr;
    bit stray;
    ext_w  = 13'h1555 ^ 13'(d1 * 97 + d2 * 31 + cm * 7);
    base_w = 13'h0A3C ^ 13'(d1 * 53 + d2 * 11 + cm * 5);
    ext_k  = 2 + d1;
    base_k = ext_k + TB_TMRD + d2;
    cd     = (cm == 0) ? -1 : (cm == 1) ? base_k + 4 : base_k + TB_LOCK;
    lock_from = (cd + 1 > base_k + 1) ? cd + 1 : base_k + 1;
    done_k = lock_from + TB_LOCK;
    stray  = (cm == 1);
    n_lmr  = 0;
    for (int k = 0; k <= done_k + 2; k++) begin
      @(negedge clk);
      // observe state of cycle k
      if (is_lmr()) n_lmr++;
      if (k == ext_k) begin
        chk(is_lmr(), "R3", "ext write pins", {cs_n, ras_n, cas_n, we_n}, 0);
        chk(ba == 2'b01, "R3", "ext bank", ba, 1);
        chk(addr == (ext_w & 13'h1FFE), "R3 R10", "ext addr", addr, ext_w & 13'h1FFE);
      end else if (k == base_k) begin
        chk(is_lmr(), "R5", "base write pins", {cs_n, ras_n, cas_n, we_n}, 0);
        chk(ba == 2'b00, "R5", "base bank", ba, 0);
        chk(addr == (base_w | 13'h0100), "R5 R10", "base addr", addr, base_w | 13'h0100);
      end else if ((k >= 1 && k < ext_k) || (k > ext_k && k < base_k)) begin
        chk(is_nop(), "R4", "stall pins", {cs_n, ras_n, cas_n, we_n}, 7);
      end else begin
        chk(is_nop(), "R2", "nop pins", {cs_n, ras_n, cas_n, we_n}, 7);
      end
      if (cm == 0) chk(done == (k == done_k), "R6", "done", done, k == done_k);
      else         chk(done == (k == done_k), "R7", "done", done, k == done_k);
      if (k >= 1)  chk(rd_ok == (k >= done_k), "R9", "rd_ok", rd_ok, k >= done_k);
      // drive inputs for cycle k
      start   = (k == 0) || (stray && (k == ext_k + 1 || k == done_k - 1));
      idle    = !((k >= 1 && k < 1 + d1) || (k >= ext_k + 1 && k < ext_k + TB_TMRD - 1 + d2));
      cke     = (k != cd);
      ext_in  = (k == 0) ? ext_w : ~ext_w;
      base_in = (k == 0) ? base_w : ~base_w;
    end
    chk(n_lmr == 2, "R11", "write count", n_lmr, 2);
    if (stray) chk(n_lmr == 2, "R8", "stray request ignored", n_lmr, 2);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog run did not end");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; idle = 1'b1; cke = 1'b1;
    ext_in = '0; base_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(is_nop() && ba == 0 && addr == 0, "R1", "reset pins", {cs_n, ras_n, cas_n, we_n}, 7);
    chk(!done && !rd_ok, "R1", "reset flags", {done, rd_ok}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(is_nop() && !done && !rd_ok, "R1", "post-reset", {cs_n, ras_n, cas_n, we_n, done, rd_ok}, 28);
    for (int d1 = 0; d1 < 3; d1++)
      for (int d2 = 0; d2 < 3; d2++)
        for (int cm = 0; cm < 3; cm++)
          run_seq(d1, d2, cm);
    report();
    $finish;
  end
endmodule